// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits beside the transmit and receive FIFOs of an SPI controller and turns their occupancy and traffic into a five-bit status word, a five-bit raw interrupt word, a masked interrupt word and a single interrupt line. It watches the current fill level of each FIFO, the push and pop strobes, the serial engine's busy flag and two programmable thresholds. Typical use sets each threshold near half the FIFO depth so software is woken while the transmit side can still accept data or once the receive side has data worth collecting.

Two of the interrupt sources follow the FIFO levels directly and need no service beyond moving data. The three error sources (transmit overflow, receive overflow, receive underflow) are sticky. They stay set until a write to the clear port removes them, one at a time or all together.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: status_o bit0 is busy_i, bit1 is high when tx_level_i equals DEPTH, bit2 is high when tx_level_i is 0, bit3 is high when rx_level_i is 0, bit4 is high when rx_level_i equals DEPTH; all follow the inputs in the same cycle.
- R2: raw_int_o bit0 (transmit low-water) is high in the same cycle whenever tx_level_i is at or below tx_thresh_i.
- R3: raw_int_o bit4 (receive high-water) is high in the same cycle whenever rx_level_i is strictly above rx_thresh_i.
- R4: A cycle with tx_push_i high while tx_level_i equals DEPTH sets raw_int_o bit1 (transmit overflow) from the next cycle on, and it stays set until cleared; a push at any lower level does not set it.
- R5: A cycle with rx_push_i high while rx_level_i equals DEPTH sets raw_int_o bit3 (receive overflow) from the next cycle on, and it stays set until cleared.
- R6: A cycle with rx_pop_i high while rx_level_i is 0 sets raw_int_o bit2 (receive underflow) from the next cycle on, and it stays set until cleared.
- R7: With clr_wr_i high, clr_data_i bit1 clears receive underflow, bit2 clears receive overflow and bit3 clears transmit overflow from the next cycle, each leaving the other sticky bits unchanged; with clr_wr_i low, clr_data_i has no effect.
- R8: With clr_wr_i high, clr_data_i bit0 clears all three sticky bits from the next cycle; the level-driven bits 0 and 4 keep following the levels.
- R9: When a sticky bit's setting event and its clear arrive in the same cycle, the bit is set afterwards.
- R10: masked_int_o is raw_int_o ANDed bitwise with int_mask_i, and irq_o is high exactly when any masked bit is high, both in the same cycle.
- R11: After reset all three sticky bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Serial engine busy flag |
| tx_level_i | input | LVL_W | Entries in the transmit FIFO |
| rx_level_i | input | LVL_W | Entries in the receive FIFO |
| tx_push_i | input | 1 | Write strobe into the transmit FIFO |
| rx_push_i | input | 1 | Write strobe into the receive FIFO |
| rx_pop_i | input | 1 | Read strobe from the receive FIFO |
| tx_thresh_i | input | LVL_W | Transmit low-water threshold |
| rx_thresh_i | input | LVL_W | Receive high-water threshold |
| int_mask_i | input | 5 | Interrupt enable mask |
| clr_wr_i | input | 1 | Write strobe for the clear port |
| clr_data_i | input | 4 | Clear bits |
| status_o | output | 5 | FIFO and engine status |
| raw_int_o | output | 5 | Unmasked interrupt sources |
| masked_int_o | output | 5 | Masked interrupt sources |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The only state in this block is the three sticky error bits, so a wrong internal value appears on raw_int_o one cycle after the faulty edge and reaches irq_o in the same cycle once the bit is unmasked. A bit that fails to latch shows up the cycle after the offending push or pop. A bit that drops by itself shows up on the next cycle with no clear. A clear that reaches the wrong bit shows up as a neighbour that changes or fails to change one cycle after the clear write. The level-driven bits hold no state, so a wrong compare is visible at once for the level applied.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int NUM_STICKY = 3;

    typedef struct packed {
        logic rx_full;
        logic rx_empty;
        logic tx_empty;
        logic tx_full;
        logic busy;
    } status_t;

    typedef struct packed {
        logic rx_high;
        logic rx_ovf;
        logic rx_udf;
        logic tx_ovf;
        logic tx_low;
    } irq_vec_t;

    // sticky vector order: [0] tx overflow, [1] rx underflow, [2] rx overflow
    function automatic logic [NUM_STICKY-1:0] decode_clear(input logic wr, input logic [3:0] data);
        logic [NUM_STICKY-1:0] c;
        c[0] = data[3];
        c[1] = data[1];
        c[2] = data[2];
        if (data[0]) c = '1;
        return wr ? c : '0;
    endfunction

endpackage

// File: rtl/spi_irq_levels.sv
module spi_irq_levels
    import spi_irq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             busy_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [LVL_W-1:0] tx_thresh_i,
    input  logic [LVL_W-1:0] rx_thresh_i,
    output status_t          status_o,
    output logic             tx_low_o,
    output logic             rx_high_o
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    always_comb begin
        status_o.busy     = busy_i;
        status_o.tx_full  = (tx_level_i == FULL_LVL);
        status_o.tx_empty = (tx_level_i == '0);
        status_o.rx_empty = (rx_level_i == '0);
        status_o.rx_full  = (rx_level_i == FULL_LVL);
        tx_low_o          = (tx_level_i <= tx_thresh_i);
        rx_high_o         = (rx_level_i >  rx_thresh_i);
    end
endmodule

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
    parameter int NBITS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBITS-1:0] set_i,
    input  logic [NBITS-1:0] clr_i,
    output logic [NBITS-1:0] q_o
);
    for (genvar k = 0; k < NBITS; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           q_o[k] <= 1'b0;
            else if (set_i[k]) q_o[k] <= 1'b1;
            else if (clr_i[k]) q_o[k] <= 1'b0;
        end

        p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
            set_i[k] |=> q_o[k]);
        p_hold_r7: assert property (@(posedge clk) disable iff (rst)
            (q_o[k] && !clr_i[k]) |=> q_o[k]);
        p_clear_r7: assert property (@(posedge clk) disable iff (rst)
            (clr_i[k] && !set_i[k]) |=> !q_o[k]);
    end
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic             tx_push_i,
    input  logic             rx_push_i,
    input  logic             rx_pop_i,
    input  logic [LVL_W-1:0] tx_thresh_i,
    input  logic [LVL_W-1:0] rx_thresh_i,
    input  logic [4:0]       int_mask_i,
    input  logic             clr_wr_i,
    input  logic [3:0]       clr_data_i,
    output logic [4:0]       status_o,
    output logic [4:0]       raw_int_o,
    output logic [4:0]       masked_int_o,
    output logic             irq_o
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

    status_t               stat;
    irq_vec_t              raw;
    logic                  tx_low, rx_high;
    logic [NUM_STICKY-1:0] err_set, err_clr, err_q;

    spi_irq_levels #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_levels (
        .busy_i     (busy_i),
        .tx_level_i (tx_level_i),
        .rx_level_i (rx_level_i),
        .tx_thresh_i(tx_thresh_i),
        .rx_thresh_i(rx_thresh_i),
        .status_o   (stat),
        .tx_low_o   (tx_low),
        .rx_high_o  (rx_high)
    );

    always_comb begin
        err_set[0] = tx_push_i && (tx_level_i == FULL_LVL);
        err_set[1] = rx_pop_i  && (rx_level_i == '0);
        err_set[2] = rx_push_i && (rx_level_i == FULL_LVL);
        err_clr    = decode_clear(clr_wr_i, clr_data_i);
    end

    spi_irq_sticky #(.NBITS(NUM_STICKY)) u_sticky (
        .clk  (clk),
        .rst  (rst),
        .set_i(err_set),
        .clr_i(err_clr),
        .q_o  (err_q)
    );

    always_comb begin
        raw.tx_low  = tx_low;
        raw.tx_ovf  = err_q[0];
        raw.rx_udf  = err_q[1];
        raw.rx_ovf  = err_q[2];
        raw.rx_high = rx_high;
    end

    assign status_o     = stat;
    assign raw_int_o    = raw;
    assign masked_int_o = raw & int_mask_i;
    assign irq_o        = |masked_int_o;

    p_tx_ovf_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_push_i && tx_level_i == FULL_LVL) |=> raw_int_o[1]);
    p_rx_ovf_r5: assert property (@(posedge clk) disable iff (rst)
        (rx_push_i && rx_level_i == FULL_LVL) |=> raw_int_o[3]);
    p_rx_udf_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_pop_i && rx_level_i == '0) |=> raw_int_o[2]);
    p_clr_all_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_wr_i && clr_data_i[0] && !tx_push_i && !rx_push_i && !rx_pop_i)
        |=> (raw_int_o[3:1] == 3'b000));
    p_full_empty_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !(status_o[1] && status_o[2]) && !(status_o[3] && status_o[4]));
    p_masked_subset_r10: assert property (@(posedge clk) disable iff (rst)
        ((masked_int_o & ~raw_int_o) == 5'b0) && (irq_o == (masked_int_o != 5'b0)));
endmodule

// File: tb/spi_fifo_irq_unit_tb.sv
module spi_fifo_irq_unit_tb;
    localparam int DEPTH = 32;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             busy_i;
    logic [LVL_W-1:0] tx_level_i, rx_level_i, tx_thresh_i, rx_thresh_i;
    logic             tx_push_i, rx_push_i, rx_pop_i, clr_wr_i;
    logic [4:0]       int_mask_i;
    logic [3:0]       clr_data_i;
    logic [4:0]       status_o, raw_int_o, masked_int_o;
    logic             irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_fifo_irq_unit #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .busy_i(busy_i),
        .tx_level_i(tx_level_i), .rx_level_i(rx_level_i),
        .tx_push_i(tx_push_i), .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i),
        .tx_thresh_i(tx_thresh_i), .rx_thresh_i(rx_thresh_i),
        .int_mask_i(int_mask_i), .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i),
        .status_o(status_o), .raw_int_o(raw_int_o),
        .masked_int_o(masked_int_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        busy_i = 0; tx_push_i = 0; rx_push_i = 0; rx_pop_i = 0;
        clr_wr_i = 0; clr_data_i = 4'h0; int_mask_i = 5'h00;
        tx_level_i = 20; rx_level_i = 5; tx_thresh_i = 15; rx_thresh_i = 15;
    endtask

    // one-cycle strobe on the given lines, then return strobes low
    task automatic pulse(input logic tp, input logic rp, input logic rpop,
                         input logic cw, input logic [3:0] cd);
        @(negedge clk);
        tx_push_i = tp; rx_push_i = rp; rx_pop_i = rpop; clr_wr_i = cw; clr_data_i = cd;
        @(negedge clk);
        tx_push_i = 0; rx_push_i = 0; rx_pop_i = 0; clr_wr_i = 0; clr_data_i = 4'h0;
        #1;
    endtask

    task automatic t_reset();
        idle_inputs();
        tx_level_i = 0; rx_level_i = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R11 reset status", status_o, 5'b01100);
        chk("R11 reset raw", raw_int_o, 5'b00001);
        chk("R10 reset irq", {4'b0, irq_o}, 5'b0);
        idle_inputs();
        #1;
        chk("R11 idle raw", raw_int_o, 5'b00000);
    endtask

    task automatic t_status();
        @(negedge clk);
        busy_i = 1; tx_level_i = DEPTH; rx_level_i = DEPTH;
        #1 chk("R1 full+busy", status_o, 5'b10011);
        busy_i = 0; tx_level_i = 7; rx_level_i = 0;
        #1 chk("R1 mid/empty", status_o, 5'b01000);
        idle_inputs();
    endtask

    task automatic t_thresholds();
        tx_level_i = 15; #1 chk("R2 tx at threshold", raw_int_o & 5'b00001, 5'b00001);
        tx_level_i = 16; #1 chk("R2 tx above threshold", raw_int_o & 5'b00001, 5'b00000);
        rx_level_i = 15; #1 chk("R3 rx at threshold", raw_int_o & 5'b10000, 5'b00000);
        rx_level_i = 16; #1 chk("R3 rx above threshold", raw_int_o & 5'b10000, 5'b10000);
        idle_inputs();
    endtask

    task automatic t_errors();
        tx_level_i = DEPTH - 1;
        pulse(1, 0, 0, 0, 4'h0);
        chk("R4 push below full", raw_int_o, 5'b00000);
        tx_level_i = DEPTH;
        pulse(1, 0, 0, 0, 4'h0);
        tx_level_i = 20;
        #1 chk("R4 tx overflow", raw_int_o, 5'b00010);
        rx_level_i = DEPTH;
        pulse(0, 1, 0, 0, 4'h0);
        rx_level_i = 5;
        #1 chk("R5 rx overflow", raw_int_o, 5'b01010);
        rx_level_i = 0;
        pulse(0, 0, 1, 0, 4'h0);
        rx_level_i = 5;
        #1 chk("R6 rx underflow", raw_int_o, 5'b01110);
        repeat (3) @(negedge clk);
        #1 chk("R4 sticky hold", raw_int_o, 5'b01110);
    endtask

    task automatic t_clears();
        pulse(0, 0, 0, 0, 4'hF);
        chk("R7 no write no effect", raw_int_o, 5'b01110);
        pulse(0, 0, 0, 1, 4'b1000);
        chk("R7 clear tx overflow", raw_int_o, 5'b01100);
        pulse(0, 0, 0, 1, 4'b0010);
        chk("R7 clear rx underflow", raw_int_o, 5'b01000);
        pulse(0, 0, 0, 1, 4'b0100);
        chk("R7 clear rx overflow", raw_int_o, 5'b00000);
        tx_level_i = DEPTH; rx_level_i = DEPTH;
        pulse(1, 1, 0, 0, 4'h0);
        rx_level_i = 0;
        pulse(0, 0, 1, 0, 4'h0);
        tx_level_i = 20; rx_level_i = 5;
        #1 chk("R6 all three set", raw_int_o, 5'b01110);
        tx_level_i = 3;
        pulse(0, 0, 0, 1, 4'b0001);
        chk("R8 clear all keeps level bit", raw_int_o, 5'b00001);
        tx_level_i = DEPTH;
        pulse(1, 0, 0, 1, 4'b1001);
        tx_level_i = 20;
        #1 chk("R9 set beats clear", raw_int_o, 5'b00010);
    endtask

    task automatic t_mask();
        rx_level_i = 25;
        int_mask_i = 5'b00000;
        #1 chk("R10 all masked", {masked_int_o[4:1], irq_o}, 5'b00000);
        int_mask_i = 5'b10000;
        #1 chk("R10 rx high unmasked", masked_int_o, 5'b10000);
        chk("R10 irq high", {4'b0, irq_o}, 5'b00001);
        int_mask_i = 5'b00101;
        #1 chk("R10 other bits", masked_int_o, 5'b00000);
        chk("R10 irq low", {4'b0, irq_o}, 5'b00000);
        int_mask_i = 5'b00010;
        #1 chk("R10 tx ovf unmasked", {masked_int_o[4:1], irq_o}, 5'b00011);
        idle_inputs();
    endtask

    initial begin
        rst = 1;
        idle_inputs();
        t_reset();
        t_status();
        t_thresholds();
        t_errors();
        t_clears();
        t_mask();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule